// File: doc/BRIEF.md
# Parallel Master Bus Engine

This block lets a host drive an external 8-bit parallel bus through a simple register-style interface. The host sets the timing, addressing and signalling options on static configuration inputs. It then starts a write by pulsing `hostWr` with a data word, or starts a read by pulsing `hostRd`. The engine runs each bus transfer in three phases: setup, strobe and hold. Each phase has its own wait-state count. A zero strobe-wait setting overrides the other two and gives the shortest possible cycle.

An 11-bit address register drives the bus address. It can stay fixed, step up or step down after every byte transfer. In wide mode, one host access becomes two byte transfers, low byte first. In narrow mode it is a single transfer. The bus can use either of two strobe styles: separate read and write strobes, or a direction line with a single enable strobe. The block shows a busy flag. Depending on its interrupt setting, it can also pulse an interrupt when an access ends, or hold a stall request to the host while the access runs.

Top module: `parBusMaster`

## Requirements
- R1: The setup phase (chip select high, no strobe, before each strobe) lasts `cfgSetup`+1 cycles, from 1 to 4.
- R2: The strobe lasts `cfgStrobe`+1 cycles, from 1 to 16.
- R3: The hold phase after the last strobe of an access lasts `cfgHold`+1 cycles. Between the two byte transfers of a wide access, chip select stays high for hold plus setup cycles.
- R4: When `cfgStrobe` is 0, setup, strobe and hold each last exactly one cycle, and `cfgSetup` and `cfgHold` have no effect.
- R5: `cfgStep` 01 adds one to the address after each byte transfer. 10 subtracts one. 00 and 11 leave it unchanged. The 11-bit address wraps around, and it stays stable while a strobe is active.
- R6: With `cfgWide`=1, an access makes two transfers: the low byte (bits 7:0) first, then the high byte (bits 15:8). With `cfgWide`=0 it makes one transfer of bits 7:0, and a read then returns zero in `rdData[15:8]`.
- R7: With `cfgStyle`=0, the strobe appears on `busRd` for reads and on `busWr` for writes, and `busEn` and `busRw` stay low. With `cfgStyle`=1, the strobe appears on `busEn`, `busRw` is 1 for a read and 0 for a write, and `busRd` and `busWr` stay low. No strobe appears without chip select.
- R8: With `cfgIrqMode`=01, `irq` is high for exactly one cycle, the first idle cycle after each access. Modes 00, 10 and 11 give no interrupt.
- R9: With `cfgIrqMode`=10, `stall` is high in exactly the cycles in which `busy` is high. In other modes it stays low.
- R10: `busy` and `busCs` go high in the cycle after a start request and stay high for (setup+strobe+hold) cycles per byte transfer.
- R11: While busy, `hostWr`, `hostRd` and `addrLoad` are ignored. After a read, `rdData` changes only when the final hold phase ends.
- R12: After reset, `busy`, `irq`, `stall`, `busCs`, `busBe`, `busRd`, `busWr`, `busRw`, `busEn` and `busDoe` are 0, and `rdData` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgSetup | input | 2 | Setup wait count minus one |
| cfgStrobe | input | 4 | Extra strobe cycles; 0 selects zero-wait timing |
| cfgHold | input | 2 | Hold wait count minus one |
| cfgStep | input | 2 | Address step: 00 fixed, 01 up, 10 down, 11 fixed |
| cfgWide | input | 1 | 1 = two byte transfers per access |
| cfgStyle | input | 1 | 0 = separate read/write strobes, 1 = direction plus enable |
| cfgIrqMode | input | 2 | 01 end-of-access interrupt, 10 host stall, else none |
| addrLoad | input | 1 | Load `addrIn` into the address register (idle only) |
| addrIn | input | 11 | Address to load |
| hostWr | input | 1 | Start a write access with `hostWrData` |
| hostRd | input | 1 | Start a read access |
| hostWrData | input | 16 | Write data word |
| rdData | output | 16 | Result of the last completed read |
| busy | output | 1 | Access in progress |
| irq | output | 1 | End-of-access interrupt pulse |
| stall | output | 1 | Stall request to the host |
| busCs | output | 1 | Chip select |
| busBe | output | 1 | Byte enable |
| busRd | output | 1 | Read strobe (separate style) |
| busWr | output | 1 | Write strobe (separate style) |
| busRw | output | 1 | Direction, 1 = read (combined style) |
| busEn | output | 1 | Enable strobe (combined style) |
| busAddr | output | 11 | Bus address |
| busDout | output | 8 | Bus write data |
| busDoe | output | 1 | Drive enable for `busDout` |
| busDin | input | 8 | Bus read data |

## Verification
The bench targets phase lengths at their extremes: a 1-cycle setup against a 4-cycle setup, a 16-cycle strobe, and the zero-wait override with setup and hold set to their maximum. A design that did not honour the override would stretch the setup and hold phases. A down-stepping wide access starting at address 1 crosses zero into 0x7FF. An address that did not wrap, or that stepped once per access instead of once per byte, would show up on the bus. Starts and address loads made in the middle of an access catch a design that restarts, changes its data or moves its address. A check of `rdData` in the middle of a wide read catches a result that is published early.

// File: rtl/parBusPkg.sv
package parBusPkg;

  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_SETUP  = 2'd1,
    PH_STROBE = 2'd2,
    PH_HOLD   = 2'd3
  } phase_e;

  // strobes from the control FSM to the datapath and pin logic
  typedef struct packed {
    logic active;    // access in progress
    logic strobe;    // strobe phase
    logic isWrite;   // current access direction
    logic combined;  // direction + enable signalling
    logic hiByte;    // second byte of a wide access
    logic loadTx;    // capture host write word
    logic capture;   // sample bus read byte
    logic step;      // apply address step
    logic stepDown;  // step direction
    logic commit;    // publish read word
  } pbmCtl_t;

endpackage

// File: rtl/pbmControl.sv
module pbmControl
  import parBusPkg::*;
#(
  parameter int SETUP_W  = 2,
  parameter int STROBE_W = 4,
  parameter int HOLD_W   = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [SETUP_W-1:0]  cfgSetup,
  input  logic [STROBE_W-1:0] cfgStrobe,
  input  logic [HOLD_W-1:0]   cfgHold,
  input  logic [1:0]          cfgStep,
  input  logic                cfgWide,
  input  logic                cfgStyle,
  input  logic [1:0]          cfgIrqMode,
  input  logic                hostWr,
  input  logic                hostRd,
  output pbmCtl_t             ctl,
  output logic                irq,
  output logic                stall
);

  localparam int CNT_W = (STROBE_W > SETUP_W)
                       ? ((STROBE_W > HOLD_W) ? STROBE_W : HOLD_W)
                       : ((SETUP_W  > HOLD_W) ? SETUP_W  : HOLD_W);

  phase_e           phaseQ;
  logic [CNT_W-1:0] cntQ;
  logic [CNT_W-1:0] setupQ;
  logic [CNT_W-1:0] strobeQ;
  logic [CNT_W-1:0] holdQ;
  logic             isWriteQ;
  logic             byteQ;
  logic             wideQ;
  logic             styleQ;
  logic [1:0]       stepQ;
  logic [1:0]       irqModeQ;

  logic             fastCycle;
  logic [CNT_W-1:0] setupLoad;
  logic [CNT_W-1:0] holdLoad;
  logic             phaseEnd;
  logic             lastByte;
  logic             startReq;

  always_comb begin
    fastCycle = (cfgStrobe == '0);
    setupLoad = fastCycle ? '0 : CNT_W'(cfgSetup);
    holdLoad  = fastCycle ? '0 : CNT_W'(cfgHold);
    phaseEnd  = (cntQ == '0);
    lastByte  = !wideQ || byteQ;
    startReq  = (phaseQ == PH_IDLE) && (hostWr || hostRd);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phaseQ   <= PH_IDLE;
      cntQ     <= '0;
      setupQ   <= '0;
      strobeQ  <= '0;
      holdQ    <= '0;
      isWriteQ <= 1'b0;
      byteQ    <= 1'b0;
      wideQ    <= 1'b0;
      styleQ   <= 1'b0;
      stepQ    <= 2'b00;
      irqModeQ <= 2'b00;
      irq      <= 1'b0;
    end else begin
      irq <= 1'b0;
      unique case (phaseQ)
        PH_IDLE: begin
          if (startReq) begin
            phaseQ   <= PH_SETUP;
            isWriteQ <= hostWr;
            byteQ    <= 1'b0;
            wideQ    <= cfgWide;
            styleQ   <= cfgStyle;
            stepQ    <= cfgStep;
            irqModeQ <= cfgIrqMode;
            setupQ   <= setupLoad;
            strobeQ  <= CNT_W'(cfgStrobe);
            holdQ    <= holdLoad;
            cntQ     <= setupLoad;
          end
        end
        PH_SETUP: begin
          if (phaseEnd) begin
            phaseQ <= PH_STROBE;
            cntQ   <= strobeQ;
          end else begin
            cntQ <= cntQ - 1'b1;
          end
        end
        PH_STROBE: begin
          if (phaseEnd) begin
            phaseQ <= PH_HOLD;
            cntQ   <= holdQ;
          end else begin
            cntQ <= cntQ - 1'b1;
          end
        end
        PH_HOLD: begin
          if (phaseEnd) begin
            if (lastByte) begin
              phaseQ <= PH_IDLE;
              irq    <= (irqModeQ == 2'b01);
            end else begin
              phaseQ <= PH_SETUP;
              byteQ  <= 1'b1;
              cntQ   <= setupQ;
            end
          end else begin
            cntQ <= cntQ - 1'b1;
          end
        end
        default: phaseQ <= PH_IDLE;
      endcase
    end
  end

  always_comb begin
    ctl.active   = (phaseQ != PH_IDLE);
    ctl.strobe   = (phaseQ == PH_STROBE);
    ctl.isWrite  = isWriteQ;
    ctl.combined = styleQ;
    ctl.hiByte   = byteQ;
    ctl.loadTx   = startReq && hostWr;
    ctl.capture  = (phaseQ == PH_STROBE) && phaseEnd && !isWriteQ;
    ctl.step     = (phaseQ == PH_HOLD) && phaseEnd && (stepQ[0] ^ stepQ[1]);
    ctl.stepDown = (stepQ == 2'b10);
    ctl.commit   = (phaseQ == PH_HOLD) && phaseEnd && lastByte && !isWriteQ;
    stall        = ctl.active && (irqModeQ == 2'b10);
  end

endmodule

// File: rtl/pbmDatapath.sv
module pbmDatapath
  import parBusPkg::*;
#(
  parameter int ADDR_W = 11,
  parameter int BYTE_W = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  pbmCtl_t             ctl,
  input  logic                addrLoad,
  input  logic [ADDR_W-1:0]   addrIn,
  input  logic [2*BYTE_W-1:0] hostWrData,
  input  logic [BYTE_W-1:0]   busDin,
  output logic [ADDR_W-1:0]   busAddr,
  output logic [BYTE_W-1:0]   busDout,
  output logic [2*BYTE_W-1:0] rdData
);

  localparam int WORD_W = 2 * BYTE_W;
  localparam int LANES  = WORD_W / BYTE_W;

  logic [ADDR_W-1:0] addrQ;
  logic [WORD_W-1:0] txQ;
  logic [WORD_W-1:0] rxQ;
  logic [WORD_W-1:0] rdQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrQ <= '0;
    end else if (addrLoad && !ctl.active) begin
      addrQ <= addrIn;
    end else if (ctl.step) begin
      addrQ <= ctl.stepDown ? addrQ - 1'b1 : addrQ + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      txQ <= '0;
    end else if (ctl.loadTx) begin
      txQ <= hostWrData;
    end
  end

  // per-lane read capture: the low lane is written by the first transfer,
  // which also clears the high lane so a narrow read returns zero there
  for (genvar lane = 0; lane < LANES; lane++) begin : gLane
    always_ff @(posedge clk) begin
      if (!rstN) begin
        rxQ[lane*BYTE_W +: BYTE_W] <= '0;
      end else if (ctl.capture) begin
        if (ctl.hiByte == (lane != 0)) begin
          rxQ[lane*BYTE_W +: BYTE_W] <= busDin;
        end else if (!ctl.hiByte) begin
          rxQ[lane*BYTE_W +: BYTE_W] <= '0;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdQ <= '0;
    end else if (ctl.commit) begin
      if (ctl.hiByte) begin
        rdQ <= {busDinHold(rxQ), rxQ[BYTE_W-1:0]};
      end else begin
        rdQ <= rxQ;
      end
    end
  end

  function automatic logic [BYTE_W-1:0] busDinHold(input logic [WORD_W-1:0] w);
    return w[WORD_W-1 -: BYTE_W];
  endfunction

  assign busAddr = addrQ;
  assign busDout = ctl.hiByte ? txQ[WORD_W-1 -: BYTE_W] : txQ[BYTE_W-1:0];
  assign rdData  = rdQ;

endmodule

// File: rtl/parBusMaster.sv
module parBusMaster
  import parBusPkg::*;
#(
  parameter int ADDR_W   = 11,
  parameter int BYTE_W   = 8,
  parameter int SETUP_W  = 2,
  parameter int STROBE_W = 4,
  parameter int HOLD_W   = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [SETUP_W-1:0]  cfgSetup,
  input  logic [STROBE_W-1:0] cfgStrobe,
  input  logic [HOLD_W-1:0]   cfgHold,
  input  logic [1:0]          cfgStep,
  input  logic                cfgWide,
  input  logic                cfgStyle,
  input  logic [1:0]          cfgIrqMode,
  input  logic                addrLoad,
  input  logic [ADDR_W-1:0]   addrIn,
  input  logic                hostWr,
  input  logic                hostRd,
  input  logic [2*BYTE_W-1:0] hostWrData,
  output logic [2*BYTE_W-1:0] rdData,
  output logic                busy,
  output logic                irq,
  output logic                stall,
  output logic                busCs,
  output logic                busBe,
  output logic                busRd,
  output logic                busWr,
  output logic                busRw,
  output logic                busEn,
  output logic [ADDR_W-1:0]   busAddr,
  output logic [BYTE_W-1:0]   busDout,
  output logic                busDoe,
  input  logic [BYTE_W-1:0]   busDin
);

  pbmCtl_t ctl;

  pbmControl #(
    .SETUP_W (SETUP_W),
    .STROBE_W(STROBE_W),
    .HOLD_W  (HOLD_W)
  ) uCtl (
    .clk       (clk),
    .rstN      (rstN),
    .cfgSetup  (cfgSetup),
    .cfgStrobe (cfgStrobe),
    .cfgHold   (cfgHold),
    .cfgStep   (cfgStep),
    .cfgWide   (cfgWide),
    .cfgStyle  (cfgStyle),
    .cfgIrqMode(cfgIrqMode),
    .hostWr    (hostWr),
    .hostRd    (hostRd),
    .ctl       (ctl),
    .irq       (irq),
    .stall     (stall)
  );

  pbmDatapath #(
    .ADDR_W(ADDR_W),
    .BYTE_W(BYTE_W)
  ) uDp (
    .clk       (clk),
    .rstN      (rstN),
    .ctl       (ctl),
    .addrLoad  (addrLoad),
    .addrIn    (addrIn),
    .hostWrData(hostWrData),
    .busDin    (busDin),
    .busAddr   (busAddr),
    .busDout   (busDout),
    .rdData    (rdData)
  );

  always_comb begin
    busy   = ctl.active;
    busCs  = ctl.active;
    busBe  = ctl.active;
    busDoe = ctl.active && ctl.isWrite;
    busRd  = ctl.active && ctl.strobe && !ctl.combined && !ctl.isWrite;
    busWr  = ctl.active && ctl.strobe && !ctl.combined && ctl.isWrite;
    busEn  = ctl.active && ctl.strobe && ctl.combined;
    busRw  = ctl.active && ctl.combined && !ctl.isWrite;
  end

endmodule

// File: rtl/parBusMasterChk.sv
module parBusMasterChk #(
  parameter int ADDR_W = 11
) (
  input logic              clk,
  input logic              rstN,
  input logic              busy,
  input logic              irq,
  input logic              stall,
  input logic              busCs,
  input logic              busRd,
  input logic              busWr,
  input logic              busRw,
  input logic              busEn,
  input logic [ADDR_W-1:0] busAddr
);

  logic anyStrobe;
  assign anyStrobe = busRd || busWr || busEn;

  assert_strobe_in_cs_R7: assert property (@(posedge clk) disable iff (!rstN)
    !busCs |-> !(anyStrobe || busRw));

  assert_one_strobe_R7: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({busRd, busWr, busEn}));

  assert_stall_in_busy_R9: assert property (@(posedge clk) disable iff (!rstN)
    stall |-> busy);

  assert_irq_pulse_R8: assert property (@(posedge clk) disable iff (!rstN)
    irq |=> !irq);

  assert_irq_at_end_R8: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> $fell(busy));

  assert_addr_steady_R5: assert property (@(posedge clk) disable iff (!rstN)
    (anyStrobe && $past(anyStrobe)) |-> $stable(busAddr));

endmodule

bind parBusMaster parBusMasterChk #(.ADDR_W(ADDR_W)) uChk (.*);

// File: tb/sim_parBusMaster.sv
module sim_parBusMaster;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [1:0]  cfgSetup = '0;
  logic [3:0]  cfgStrobe = '0;
  logic [1:0]  cfgHold = '0;
  logic [1:0]  cfgStep = '0;
  logic        cfgWide = 1'b0;
  logic        cfgStyle = 1'b0;
  logic [1:0]  cfgIrqMode = '0;
  logic        addrLoad = 1'b0;
  logic [10:0] addrIn = '0;
  logic        hostWr = 1'b0;
  logic        hostRd = 1'b0;
  logic [15:0] hostWrData = '0;
  logic [15:0] rdData;
  logic        busy, irq, stall, busCs, busBe, busRd, busWr, busRw, busEn, busDoe;
  logic [10:0] busAddr;
  logic [7:0]  busDout;
  logic [7:0]  busDin;

  always #5 clk = ~clk;

  function automatic logic [7:0] devByte(input logic [10:0] a);
    return a[7:0] ^ {a[10:8], 5'h1A};
  endfunction

  assign busDin = devByte(busAddr);

  parBusMaster u0 (.*);

  int checks = 0;
  int fails = 0;
  int irqCnt = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string msg);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s", msg);
    end
  endtask

  typedef struct {
    bit          wr;
    logic [10:0] addr;
    logic [7:0]  data;
    int          pre;
    int          stb;
    bit          last;
    int          hold;
  } item_t;

  item_t       q[$];
  logic [10:0] mAddr = '0;
  logic [15:0] lastRd = '0;

  // ---------------- monitor ----------------
  bit          inStb = 0, prevCs = 0, capRead = 0, styleOk = 0, lastSeen = 0;
  int          gap = 0, sc = 0, pre = 0, expHold = 0;
  logic [10:0] capAddr;
  logic [7:0]  capData;

  always @(negedge clk) begin
    if (rstN) begin
      if (busCs) begin
        if (cfgStyle ? busEn : (busRd || busWr)) begin
          if (!inStb) begin
            inStb   = 1;
            sc      = 0;
            pre     = gap;
            capRead = cfgStyle ? busRw : busRd;
            capAddr = busAddr;
            capData = capRead ? busDin : busDout;
            styleOk = cfgStyle ? (!busRd && !busWr && busRw == capRead)
                               : (!busEn && !busRw);
          end
          sc++;
        end else if (inStb) begin
          inStb = 0;
          if (q.size() == 0) begin
            chk(0, "R11 transfer with no access pending");
          end else begin
            item_t it;
            it = q.pop_front();
            chk(capRead == !it.wr, $sformatf("R7 direction read=%0d exp %0d", capRead, !it.wr));
            chk(capAddr == it.addr, $sformatf("R5 address %h exp %h", capAddr, it.addr));
            chk(capData == it.data, $sformatf("R6 byte %h exp %h", capData, it.data));
            chk(pre == it.pre, $sformatf("R1/R4 setup gap %0d exp %0d", pre, it.pre));
            chk(sc == it.stb, $sformatf("R2 strobe %0d exp %0d", sc, it.stb));
            chk(styleOk, $sformatf("R7 strobe style lines wrong style=%0d exp 1", styleOk));
            expHold  = it.hold;
            lastSeen = it.last;
          end
          gap = 1;
        end else begin
          gap++;
        end
      end else begin
        if (prevCs) begin
          chk(lastSeen && gap == expHold,
              $sformatf("R3 hold %0d last=%0d exp %0d", gap, lastSeen, expHold));
        end
        gap   = 0;
        inStb = 0;
      end
      prevCs = busCs;
      if (irq) irqCnt++;
    end
  end

  // ---------------- driver ----------------
  task automatic loadAddr(input logic [10:0] a);
    @(negedge clk);
    addrLoad = 1'b1;
    addrIn   = a;
    @(negedge clk);
    addrLoad = 1'b0;
    mAddr    = a;
  endtask

  function automatic logic [10:0] nextAddr(input logic [10:0] a);
    if (cfgStep == 2'b01) return a + 11'd1;
    if (cfgStep == 2'b10) return a - 11'd1;
    return a;
  endfunction

  task automatic access(input bit wr, input logic [15:0] wdata, input bit intrude);
    int s, m, h, n, busyCnt, stallCnt, irqBefore;
    logic [15:0] expRd;
    s = (cfgStrobe == 0) ? 1 : int'(cfgSetup) + 1;
    m = int'(cfgStrobe) + 1;
    h = (cfgStrobe == 0) ? 1 : int'(cfgHold) + 1;
    n = cfgWide ? 2 : 1;
    expRd = '0;
    for (int b = 0; b < n; b++) begin
      item_t it;
      it.wr   = wr;
      it.addr = mAddr;
      it.data = wr ? wdata[b*8 +: 8] : devByte(mAddr);
      it.pre  = (b == 0) ? s : h + s;
      it.stb  = m;
      it.last = (b == n - 1);
      it.hold = h;
      if (!wr) expRd[b*8 +: 8] = devByte(mAddr);
      q.push_back(it);
      mAddr = nextAddr(mAddr);
    end
    irqBefore = irqCnt;
    @(negedge clk);
    hostWr     = wr;
    hostRd     = !wr;
    hostWrData = wdata;
    @(negedge clk);
    hostWr = 1'b0;
    hostRd = 1'b0;
    chk(busy && busCs, $sformatf("R10 busy=%0d cs=%0d after start exp 1", busy, busCs));
    busyCnt  = 0;
    stallCnt = 0;
    while (busy) begin
      busyCnt++;
      if (stall) stallCnt++;
      hostWr   = intrude && busyCnt == 2;
      hostRd   = intrude && busyCnt == 2;
      addrLoad = intrude && busyCnt == 2;
      addrIn   = 11'h155;
      hostWrData = 16'hDEAD;
      if (intrude && busyCnt == 3 && !wr)
        chk(rdData == lastRd, $sformatf("R11 rdData mid-read %h exp %h", rdData, lastRd));
      @(negedge clk);
    end
    hostWr   = 1'b0;
    hostRd   = 1'b0;
    addrLoad = 1'b0;
    chk(busyCnt == n * (s + m + h), $sformatf("R10 busy cycles %0d exp %0d", busyCnt, n * (s + m + h)));
    chk(stallCnt == ((cfgIrqMode == 2'b10) ? busyCnt : 0),
        $sformatf("R9 stall cycles %0d exp %0d", stallCnt, (cfgIrqMode == 2'b10) ? busyCnt : 0));
    @(negedge clk);
    chk(irqCnt - irqBefore == ((cfgIrqMode == 2'b01) ? 1 : 0),
        $sformatf("R8 irq pulses %0d exp %0d", irqCnt - irqBefore, (cfgIrqMode == 2'b01) ? 1 : 0));
    if (!wr) begin
      chk(rdData == expRd, $sformatf("R6 read word %h exp %h", rdData, expRd));
      lastRd = expRd;
    end
    chk(q.size() == 0, $sformatf("R11 items left %0d exp 0", q.size()));
    repeat (2) @(negedge clk);
  endtask

  task automatic setCfg(input logic [1:0] su, input logic [3:0] st, input logic [1:0] ho,
                        input logic [1:0] sp, input bit wide, input bit sty, input logic [1:0] im);
    @(negedge clk);
    cfgSetup = su; cfgStrobe = st; cfgHold = ho; cfgStep = sp;
    cfgWide = wide; cfgStyle = sty; cfgIrqMode = im;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R12 reset state
    chk({busy, irq, stall, busCs, busBe, busRd, busWr, busRw, busEn, busDoe} == '0,
        "R12 control outputs not idle after reset");
    chk(rdData == 16'h0, $sformatf("R12 rdData %h exp 0000", rdData));

    loadAddr(11'h010);
    // separate strobes, short timing, step up, narrow
    setCfg(2'd1, 4'd2, 2'd1, 2'b01, 1'b0, 1'b0, 2'b01);
    access(1'b1, 16'h00A5, 1'b0);
    access(1'b0, 16'h0000, 1'b0);
    // wide, long setup, no hold extension, intrusions
    setCfg(2'd3, 4'd5, 2'd0, 2'b01, 1'b1, 1'b0, 2'b00);
    access(1'b1, 16'h3C96, 1'b1);
    access(1'b0, 16'h0000, 1'b1);
    // zero-wait override, combined style, step down with wrap, stall mode
    loadAddr(11'h001);
    setCfg(2'd3, 4'd0, 2'd3, 2'b10, 1'b1, 1'b1, 2'b10);
    access(1'b0, 16'h0000, 1'b0);
    access(1'b1, 16'hBEEF, 1'b0);
    // longest strobe, fixed address, narrow, combined style
    setCfg(2'd0, 4'd15, 2'd1, 2'b00, 1'b0, 1'b1, 2'b01);
    access(1'b1, 16'h005A, 1'b1);
    access(1'b0, 16'h0000, 1'b0);
    // step mode 11 keeps the address; no-interrupt mode 11
    setCfg(2'd2, 4'd1, 2'd2, 2'b11, 1'b1, 1'b0, 2'b11);
    access(1'b1, 16'h1234, 1'b0);
    access(1'b0, 16'h0000, 1'b0);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule